// File: doc/BRIEF.md
# PLL Clock Controller

This block decides when an on-chip PLL, which multiplies its reference by eight, is running and which reference it is fed. With the full 8 MHz RC reference the fast peripheral clock is 64 MHz. When the reference-halving bit is set, the RC output is divided by two before the PLL, so the fast clock is 32 MHz.

The PLL runs when software asks for it, or when the clock-select fuse picks a mode that needs it. Two fuse codes need it: one makes the PLL the system clock, and the other selects a legacy compatibility clocking mode. The halving bit cannot be set while the PLL is the system clock. The deep sleep states stop both the RC oscillator and the PLL, whatever the other enable sources say.

The analog lock indication passes through a two-flop synchronizer before software can see it. It is cleared whenever the PLL stops or its reference frequency changes. After that it waits for a fresh lock.

Top module: `pllctl_top`

## Requirements
- R1: When the sleep code is 2'b00 or 2'b01, `pll_en` is 1 if and only if at least one of these holds: the software enable bit (register bit 1) is 1, `fuse_clksel` is 4'b0001, or `fuse_clksel` is 4'b0011.
- R2: `sysclk_src` is 2'd1 (PLL output) when `fuse_clksel` is 4'b0001, 2'd2 (compatibility mode) when it is 4'b0011, and 2'd0 for every other fuse value.
- R3: `ref_half` equals the low-speed bit (register bit 2). 0 means the full RC reference (64 MHz fast clock) and 1 means the halved reference (32 MHz fast clock).
- R4: While `fuse_clksel` is 4'b0001, a write with bit 2 set leaves the low-speed bit at 0 and `ref_half` low.
- R5: Sleep codes 2'b10 (power-down) and 2'b11 (standby) drive both `pll_en` and `osc_en` low. Codes 2'b00 (active) and 2'b01 (idle) keep `osc_en` high.
- R6: The control word reads {5'b0, low-speed, sw-enable, lock}. Bit 0 is read-only: a write to it has no effect. Bits 7:3 always read 0.
- R7: Synchronous active-high reset clears the sw-enable bit, the low-speed bit and the lock flag, even if a write is presented in the same cycle.
- R8: A high lock input reaches `lock_flag` through two synchronizer flops and one flag flop. The flag rises after the third rising edge at which the input was sampled high.
- R9: `lock_flag` (and register bit 0) is low in every cycle in which `pll_en` is low.
- R10: Any change of the low-speed bit clears the lock flag and flushes the synchronizer at the same edge. The flag reasserts only after a fresh three-edge pass of the lock input.
- R11: On leaving power-down or standby, `pll_en` returns at once to its R1 value. `lock_flag` stays low until a fresh synchronized lock has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_clksel | input | 4 | Clock-select fuse value |
| sleep_mode | input | 2 | 00 active, 01 idle, 10 power-down, 11 standby |
| bus_wr_en | input | 1 | Write strobe for the control word |
| bus_wr_data | input | 8 | Write data for the control word |
| bus_rd_data | output | 8 | Control/status word read value |
| pll_lock_raw | input | 1 | Asynchronous lock indication from the PLL |
| pll_en | output | 1 | PLL enable |
| ref_half | output | 1 | Select halved RC reference for the PLL |
| osc_en | output | 1 | RC oscillator enable |
| lock_flag | output | 1 | Synchronized lock status |
| sysclk_src | output | 2 | System clock source select |

## Verification
The hardest case to reach is a synchronizer flush while the lock input stays high. This happens on a low-speed change, or on a wake from deep sleep, while lock is still present. Without the flush, the flag would come back one or two edges too early, and an input that keeps dropping hides that error.

To reach this case, the bench ORs a hold-high override into the output of its lock stub. It then toggles the low-speed bit, or wakes from power-down, with the lock line high. It measures the exact edge at which the flag returns. The bench also sweeps every combination of fuse code, sleep code and software enable, with a low-speed write in each combination.

// File: rtl/pllctl_pkg.sv
package pllctl_pkg;

    localparam int REG_W      = 8;
    localparam int SYNC_DEPTH = 2;

    localparam int BIT_LOCK = 0;
    localparam int BIT_EN   = 1;
    localparam int BIT_LSM  = 2;

    typedef logic [3:0] fuse_t;

    localparam fuse_t FUSE_PLL_SYS = 4'b0001;
    localparam fuse_t FUSE_COMPAT  = 4'b0011;

    typedef enum logic [1:0] {
        SLP_ACTIVE = 2'd0,
        SLP_IDLE   = 2'd1,
        SLP_PWRDN  = 2'd2,
        SLP_STBY   = 2'd3
    } sleep_e;

    typedef enum logic [1:0] {
        SRC_FUSE   = 2'd0,
        SRC_PLL    = 2'd1,
        SRC_COMPAT = 2'd2
    } clksrc_e;

    typedef struct packed {
        logic lsm;
        logic sw_en;
    } ctl_t;

    function automatic logic osc_stopped(logic [1:0] mode);
        return (mode == SLP_PWRDN) || (mode == SLP_STBY);
    endfunction

    function automatic logic fuse_needs_pll(fuse_t f);
        return (f == FUSE_PLL_SYS) || (f == FUSE_COMPAT);
    endfunction

    function automatic clksrc_e decode_src(fuse_t f);
        if (f == FUSE_PLL_SYS) return SRC_PLL;
        if (f == FUSE_COMPAT)  return SRC_COMPAT;
        return SRC_FUSE;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(ctl_t c, logic lock);
        logic [REG_W-1:0] w;
        w           = '0;
        w[BIT_LOCK] = lock;
        w[BIT_EN]   = c.sw_en;
        w[BIT_LSM]  = c.lsm;
        return w;
    endfunction

endpackage

// File: rtl/pllctl_regs.sv
module pllctl_regs
    import pllctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         lsm_block,
    output ctl_t         ctl,
    output logic         lsm_chg
);

    logic lsm_next;

    always_comb begin
        lsm_next = ctl.lsm;
        if (wr_en)
            lsm_next = wr_data[BIT_LSM];
        if (lsm_block)
            lsm_next = 1'b0;
        lsm_chg = (lsm_next != ctl.lsm);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            if (wr_en)
                ctl.sw_en <= wr_data[BIT_EN];
            ctl.lsm <= lsm_next;
        end
    end

    // R4
    lsm_refused_chk: assert property (@(posedge clk) disable iff (rst)
        lsm_block |=> !ctl.lsm);

    // R6
    swen_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ctl.sw_en == $past(wr_data[BIT_EN]));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> ctl == '0);

endmodule

// File: rtl/pllctl_enable.sv
module pllctl_enable
    import pllctl_pkg::*;
(
    input  fuse_t      fuse,
    input  logic [1:0] sleep_mode,
    input  logic       sw_en,
    output logic       pll_en,
    output logic       osc_en,
    output clksrc_e    src
);

    logic stopped;
    logic want_pll;

    always_comb begin
        stopped  = osc_stopped(sleep_mode);
        want_pll = sw_en | fuse_needs_pll(fuse);
        pll_en   = want_pll & ~stopped;
        osc_en   = ~stopped;
        src      = decode_src(fuse);
    end

endmodule

// File: rtl/pllctl_lock_sync.sv
module pllctl_lock_sync
    import pllctl_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic lock_raw,
    input  logic enable,
    input  logic flush,
    output logic lock_flag
);

    logic [STAGES-1:0] chain;
    logic              lock_q;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("pllctl_lock_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !enable || flush) begin
            chain  <= '0;
            lock_q <= 1'b0;
        end else begin
            chain  <= {chain[STAGES-2:0], lock_raw};
            lock_q <= chain[STAGES-1];
        end
    end

    assign lock_flag = lock_q & enable;

    // R9
    lock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !lock_q);

    // R10
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lock_q && (chain == '0));

endmodule

// File: rtl/pllctl_top.sv
module pllctl_top
    import pllctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   fuse_clksel,
    input  logic [1:0]   sleep_mode,
    input  logic         bus_wr_en,
    input  logic [W-1:0] bus_wr_data,
    output logic [W-1:0] bus_rd_data,
    input  logic         pll_lock_raw,
    output logic         pll_en,
    output logic         ref_half,
    output logic         osc_en,
    output logic         lock_flag,
    output logic [1:0]   sysclk_src
);

    ctl_t    ctl;
    logic    lsm_chg;
    clksrc_e src;

    pllctl_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr_en),
        .wr_data   (bus_wr_data),
        .lsm_block (fuse_clksel == FUSE_PLL_SYS),
        .ctl       (ctl),
        .lsm_chg   (lsm_chg)
    );

    pllctl_enable u_enable (
        .fuse       (fuse_clksel),
        .sleep_mode (sleep_mode),
        .sw_en      (ctl.sw_en),
        .pll_en     (pll_en),
        .osc_en     (osc_en),
        .src        (src)
    );

    pllctl_lock_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .lock_raw  (pll_lock_raw),
        .enable    (pll_en),
        .flush     (lsm_chg),
        .lock_flag (lock_flag)
    );

    always_comb begin
        ref_half    = ctl.lsm;
        sysclk_src  = src;
        bus_rd_data = pack_word(ctl, lock_flag) | {W{1'b0}};
    end

    // R1
    pll_request_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_mode[1] && (bus_rd_data[BIT_EN] || fuse_needs_pll(fuse_clksel)) |-> pll_en);

    // R5
    deep_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_mode[1] |-> !pll_en && !osc_en);

    // R2
    pll_sysclk_chk: assert property (@(posedge clk) disable iff (rst)
        (fuse_clksel == 4'b0001) |-> sysclk_src == 2'd1);

    // R8
    lock_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_flag) |-> $past(pll_lock_raw, 3));

    // R10
    lsm_unlock_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(ref_half) |-> !lock_flag);

endmodule

// File: tb/tb_pllctl_top.sv
`timescale 1ns/1ps
module tb_pllctl_top;

    localparam int STUB_DLY = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] fuse_clksel = 4'd0;
    logic [1:0] sleep_mode = 2'd0;
    logic       bus_wr_en = 1'b0;
    logic [7:0] bus_wr_data = 8'd0;
    logic [7:0] bus_rd_data;
    logic       pll_lock_raw;
    logic       pll_en, ref_half, osc_en, lock_flag;
    logic [1:0] sysclk_src;

    logic raw_hold = 1'b0;
    int   stub_cnt = 0;
    logic stub_ref = 1'b0;
    logic stub_lock;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pllctl_top dut (
        .clk(clk), .rst(rst), .fuse_clksel(fuse_clksel), .sleep_mode(sleep_mode),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_data(bus_rd_data),
        .pll_lock_raw(pll_lock_raw), .pll_en(pll_en), .ref_half(ref_half),
        .osc_en(osc_en), .lock_flag(lock_flag), .sysclk_src(sysclk_src)
    );

    // behavioural PLL: locks STUB_DLY edges after enable with a steady reference
    always_ff @(posedge clk) begin
        if (pll_en !== 1'b1 || ref_half !== stub_ref)
            stub_cnt <= 0;
        else if (stub_cnt < STUB_DLY)
            stub_cnt <= stub_cnt + 1;
        stub_ref <= ref_half;
    end
    assign stub_lock    = (pll_en === 1'b1) && (ref_half === stub_ref) && (stub_cnt == STUB_DLY);
    assign pll_lock_raw = stub_lock | raw_hold;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write(logic [7:0] d);
        bus_wr_en   = 1'b1;
        bus_wr_data = d;
        step();
        bus_wr_en   = 1'b0;
    endtask

    // flag must be low after edges 1..n-1 and high after edge n (n counted from now)
    task automatic expect_lock_at(int n, string req);
        for (int i = 1; i < n; i++) begin
            step();
            check(req, {7'd0, lock_flag}, 8'd0);
        end
        step();
        check(req, {7'd0, lock_flag}, 8'd1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        // R7: write during reset must be lost
        bus_wr_en   = 1'b1;
        bus_wr_data = 8'h06;
        repeat (3) step();
        bus_wr_en = 1'b0;
        rst       = 1'b0;
        #1;
        check("R7 rd", bus_rd_data, 8'h00);
        check("R7 pll_en", {7'd0, pll_en}, 8'd0);
        check("R7 ref_half", {7'd0, ref_half}, 8'd0);
        check("R7 lock", {7'd0, lock_flag}, 8'd0);

        // R1 R2 R3 R4 R5 R6 R9: full sweep of fuse x sleep x sw-enable
        for (int f = 0; f < 16; f++) begin
            for (int s = 0; s < 4; s++) begin
                for (int e = 0; e < 2; e++) begin
                    logic exp_sys, exp_pll, exp_osc, exp_lsm;
                    logic [1:0] exp_src;
                    fuse_clksel = 4'(f);
                    sleep_mode  = 2'(s);
                    write(8'h05 | 8'(e << 1));
                    exp_sys = (f == 1);
                    exp_lsm = !exp_sys;
                    exp_osc = (s < 2);
                    exp_pll = ((e == 1) || f == 1 || f == 3) && exp_osc;
                    exp_src = (f == 1) ? 2'd1 : (f == 3) ? 2'd2 : 2'd0;
                    check("R1 pll_en", {7'd0, pll_en}, {7'd0, exp_pll});
                    check("R2 sysclk_src", {6'd0, sysclk_src}, {6'd0, exp_src});
                    check("R3 ref_half", {7'd0, ref_half}, {7'd0, exp_lsm});
                    check("R4 R6 rd", bus_rd_data & 8'hFE, {5'd0, exp_lsm, 1'(e), 1'b0});
                    check("R5 osc_en", {7'd0, osc_en}, {7'd0, exp_osc});
                    if (!exp_pll)
                        check("R9 lock off", {7'd0, lock_flag}, 8'd0);
                end
            end
        end

        // R6: bit 0 is read-only, reserved bits read zero
        fuse_clksel = 4'd0;
        sleep_mode  = 2'd3;
        write(8'h00);
        write(8'hF9);
        check("R6 ro bits", bus_rd_data, 8'h00);
        write(8'h00);
        repeat (2) step();

        // R8: enable by software, stub locks, flag after stub + sync latency
        sleep_mode = 2'd0;
        write(8'h02);
        expect_lock_at(STUB_DLY + 3, "R8 lock latency");
        check("R8 rd bit0", bus_rd_data, 8'h03);

        // R3 R10: lsm change drops lock, waits for fresh lock
        write(8'h06);
        check("R3 ref_half set", {7'd0, ref_half}, 8'd1);
        check("R10 lock cleared", {7'd0, lock_flag}, 8'd0);
        expect_lock_at(STUB_DLY + 4, "R10 relock");

        // R10: lsm change with lock held high must still flush the chain
        raw_hold = 1'b1;
        write(8'h02);
        check("R10 flush now", {7'd0, lock_flag}, 8'd0);
        expect_lock_at(3, "R10 flush relock");
        raw_hold = 1'b0;
        repeat (STUB_DLY + 4) step();
        check("R8 steady lock", {7'd0, lock_flag}, 8'd1);

        // R9 R11: power-down stops everything, wake relocks from scratch
        sleep_mode = 2'd2;
        #1;
        check("R5 pd pll_en", {7'd0, pll_en}, 8'd0);
        check("R5 pd osc_en", {7'd0, osc_en}, 8'd0);
        check("R9 immediate drop", {7'd0, lock_flag}, 8'd0);
        repeat (3) step();
        sleep_mode = 2'd0;
        #1;
        check("R11 pll_en back", {7'd0, pll_en}, 8'd1);
        check("R11 lock low", {7'd0, lock_flag}, 8'd0);
        expect_lock_at(STUB_DLY + 3, "R11 wake relock");

        // R11: wake from standby with lock held high, flag waits for sync
        sleep_mode = 2'd3;
        raw_hold   = 1'b1;
        repeat (3) step();
        sleep_mode = 2'd0;
        #1;
        check("R11 hold low", {7'd0, lock_flag}, 8'd0);
        expect_lock_at(3, "R11 hold relock");
        raw_hold = 1'b0;

        // R4: fuse selects PLL as system clock while lsm is 1 -> forced off
        write(8'h06);
        check("R3 lsm on", {7'd0, ref_half}, 8'd1);
        fuse_clksel = 4'b0001;
        step();
        check("R4 forced clear", {7'd0, ref_half}, 8'd0);

        done = 1'b1;
        finish_run();
    end

endmodule